// File: doc/BRIEF.md
# Multicore level interrupt router

The block gathers 32 level-sensitive interrupt request lines and routes them onto a grid of 16 outputs. The grid has 4 processor cores with 4 interrupt lines per core. Each input owns a one-byte routing entry. The low nibble of that byte is a set of target cores and the high nibble is a set of target lines. A global enable mask gates every input. The mask changes only through a write-one-to-set register and a write-one-to-clear register.

Status is never latched. Every cycle the block recomputes the enabled status from the pin levels, the mask and the routing table. Software can read the enabled status, the enable mask, the routing bytes and one status word per core over a small register bus. The bus takes byte and word accesses and returns read data one cycle after the request.

Top module: `irq_router`

## Requirements
- R1: After reset all routing bytes and the enable mask are zero, `irq_o` is all zero and `rvalid_o` is low.
- R2: Each routing byte sits at offset 0x00 + input index and is reached only by byte accesses (`size_i` = 0). Write data is taken from `wdata_i[7:0]` and read data is zero-extended. Bits 0-3 of the byte select cores 0-3 and bits 4-7 select lines 0-3.
- R3: A word read at 0x20 returns the bitwise AND of the current `irq_i` levels and the enable mask, with no latching.
- R4: A word write to 0x28 sets every enable bit that is 1 in the data and leaves the others unchanged. A word read at 0x24 returns the mask.
- R5: A word write to 0x2C clears every enable bit that is 1 in the data and leaves the others unchanged.
- R6: A word read at 0x40 + 8 x core (cores 0-3) returns one bit for each enabled active input whose routing byte selects that core.
- R7: Output bit 4 x core + line is high when two conditions both hold: that core's status word is nonzero, and some enabled active input selects that line. The two conditions may be met by different inputs.
- R8: `irq_o` is registered. It reflects the pins, mask and routing that were present before the previous rising clock edge.
- R9: Each read request (`req_i` high, `we_i` low) yields `rvalid_o` high for exactly the next cycle. `rvalid_o` is low in all other cycles.
- R10: Outside the routing bytes, an access that is not a word access (`size_i` = 2) or that is not 4-byte aligned is ignored, and a read of that kind returns zero. A word access to 0x00-0x1F is also ignored.
- R11: Reads of unmapped offsets return zero. Writes to 0x20, 0x24, the per-core status words and unmapped offsets change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_i | input | 32 | Level interrupt inputs |
| req_i | input | 1 | Bus access request |
| we_i | input | 1 | 1 = write, 0 = read |
| size_i | input | 2 | Access size: 0 byte, 1 half, 2 word, 3 reserved |
| addr_i | input | 7 | Byte offset |
| wdata_i | input | 32 | Write data |
| rvalid_o | output | 1 | Read data valid, one cycle after a read request |
| rdata_o | output | 32 | Read data |
| irq_o | output | 16 | Routed outputs, index 4 x core + line |

## Verification
The assertions check the following on every cycle:
- the set and clear semantics of the mask;
- that routing bytes stay put without a byte write;
- the one-cycle read strobe;
- zero data for malformed reads;
- that no output rises unless some enabled input was active one cycle earlier.

The pairing rule of R7 can only be shown by the bench's scenarios. Those scenarios cover the core from one input and the line from another, the fan-out of one input to all 16 outputs, and the one-cycle output lag. The same holds for the absence of effect from writes to status and unmapped words, which the bench shows by reading the state back. A behavioural model runs alongside to compare outputs and read data under random traffic.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;
  localparam int unsigned N_IN   = 32;
  localparam int unsigned N_CORE = 4;
  localparam int unsigned N_LINE = 4;
  localparam int unsigned N_OUT  = N_CORE * N_LINE;
  localparam int unsigned RT_W   = N_CORE + N_LINE;
  localparam int unsigned IW     = $clog2(N_IN);
  localparam int unsigned AW     = 7;
  localparam int unsigned DW     = 32;
  localparam int unsigned CORE_STRIDE = 8;

  localparam logic [AW-1:0] A_STAT      = 7'h20;
  localparam logic [AW-1:0] A_EN        = 7'h24;
  localparam logic [AW-1:0] A_EN_SET    = 7'h28;
  localparam logic [AW-1:0] A_EN_CLR    = 7'h2C;
  localparam logic [AW-1:0] A_CORE_BASE = 7'h40;

  typedef logic [RT_W-1:0] route_t;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } acc_size_e;
endpackage

// File: rtl/irq_router_cfg.sv
module irq_router_cfg
  import irq_router_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                route_we_i,
  input  logic [IW-1:0]       route_idx_i,
  input  logic [RT_W-1:0]     route_wd_i,
  input  logic                en_set_i,
  input  logic                en_clr_i,
  input  logic [N_IN-1:0]     en_wd_i,
  output route_t [N_IN-1:0]   route_o,
  output logic [N_IN-1:0]     en_o
);
  route_t [N_IN-1:0] route_q;
  logic   [N_IN-1:0] en_q;

  for (genvar i = 0; i < N_IN; i++) begin : g_route
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) route_q[i] <= '0;
      else if (route_we_i && route_idx_i == IW'(i)) route_q[i] <= route_wd_i;
    end
  end

  // set and clear live at distinct offsets, never both in one cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       en_q <= '0;
    else if (en_set_i) en_q <= en_q | en_wd_i;
    else if (en_clr_i) en_q <= en_q & ~en_wd_i;
  end

  assign route_o = route_q;
  assign en_o    = en_q;

  p_en_set_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_set_i |=> ((en_q & $past(en_wd_i)) == $past(en_wd_i)));
  p_en_clr_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_clr_i |=> ((en_q & $past(en_wd_i)) == '0));
  p_en_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_set_i && !en_clr_i) |=> $stable(en_q));
  p_route_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !route_we_i |=> $stable(route_q));
endmodule

// File: rtl/irq_router_map.sv
module irq_router_map
  import irq_router_pkg::*;
(
  input  logic [N_IN-1:0]             pins_i,
  input  logic [N_IN-1:0]             en_i,
  input  route_t [N_IN-1:0]           route_i,
  output logic [N_IN-1:0]             stat_o,
  output logic [N_CORE-1:0][N_IN-1:0] core_stat_o,
  output logic [N_OUT-1:0]            irq_nxt_o
);
  logic [N_LINE-1:0] line_hit;

  assign stat_o = pins_i & en_i;

  for (genvar c = 0; c < N_CORE; c++) begin : g_core
    for (genvar i = 0; i < N_IN; i++) begin : g_in
      assign core_stat_o[c][i] = stat_o[i] & route_i[i][c];
    end
  end

  for (genvar l = 0; l < N_LINE; l++) begin : g_line
    logic [N_IN-1:0] col;
    for (genvar i = 0; i < N_IN; i++) begin : g_in
      assign col[i] = stat_o[i] & route_i[i][N_CORE+l];
    end
    assign line_hit[l] = |col;
  end

  for (genvar c = 0; c < N_CORE; c++) begin : g_oc
    for (genvar l = 0; l < N_LINE; l++) begin : g_ol
      assign irq_nxt_o[c*N_LINE+l] = (|core_stat_o[c]) & line_hit[l];
    end
  end
endmodule

// File: rtl/irq_router_rd.sv
module irq_router_rd
  import irq_router_pkg::*;
(
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        rd_en_i,
  input  logic                        route_acc_i,
  input  logic                        word_acc_i,
  input  logic [AW-1:0]               addr_i,
  input  route_t [N_IN-1:0]           route_i,
  input  logic [N_IN-1:0]             en_i,
  input  logic [N_IN-1:0]             stat_i,
  input  logic [N_CORE-1:0][N_IN-1:0] core_stat_i,
  output logic                        rvalid_o,
  output logic [DW-1:0]               rdata_o
);
  logic [DW-1:0] rdata_nxt;
  logic [DW-1:0] rdata_q;
  logic          rvalid_q;

  always_comb begin
    rdata_nxt = '0;
    if (route_acc_i) begin
      rdata_nxt = DW'(route_i[addr_i[IW-1:0]]);
    end else if (word_acc_i) begin
      if (addr_i == A_STAT)    rdata_nxt = DW'(stat_i);
      else if (addr_i == A_EN) rdata_nxt = DW'(en_i);
      else begin
        for (int c = 0; c < int'(N_CORE); c++) begin
          if (addr_i == A_CORE_BASE + AW'(c * CORE_STRIDE)) rdata_nxt = DW'(core_stat_i[c]);
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rvalid_q <= 1'b0;
      rdata_q  <= '0;
    end else begin
      rvalid_q <= rd_en_i;
      rdata_q  <= rd_en_i ? rdata_nxt : '0;
    end
  end

  assign rvalid_o = rvalid_q;
  assign rdata_o  = rdata_q;

  p_rvalid_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i |=> rvalid_o);
  p_rvalid_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> !rvalid_o);
  p_bad_read_zero_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && !route_acc_i && !word_acc_i) |=> (rdata_o == '0));
endmodule

// File: rtl/irq_router.sv
module irq_router
  import irq_router_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_IN-1:0]   irq_i,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [1:0]        size_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [DW-1:0]     wdata_i,
  output logic              rvalid_o,
  output logic [DW-1:0]     rdata_o,
  output logic [N_OUT-1:0]  irq_o
);
  route_t [N_IN-1:0]           route;
  logic [N_IN-1:0]             en;
  logic [N_IN-1:0]             stat;
  logic [N_CORE-1:0][N_IN-1:0] core_stat;
  logic [N_OUT-1:0]            irq_nxt;
  logic [N_OUT-1:0]            irq_q;
  logic                        route_acc;
  logic                        word_acc;

  assign route_acc = req_i && (size_i == SZ_BYTE) && (addr_i < AW'(N_IN));
  assign word_acc  = req_i && (size_i == SZ_WORD) && (addr_i[1:0] == 2'b00);

  irq_router_cfg u_cfg (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .route_we_i  (route_acc && we_i),
    .route_idx_i (addr_i[IW-1:0]),
    .route_wd_i  (wdata_i[RT_W-1:0]),
    .en_set_i    (word_acc && we_i && addr_i == A_EN_SET),
    .en_clr_i    (word_acc && we_i && addr_i == A_EN_CLR),
    .en_wd_i     (wdata_i[N_IN-1:0]),
    .route_o     (route),
    .en_o        (en)
  );

  irq_router_map u_map (
    .pins_i      (irq_i),
    .en_i        (en),
    .route_i     (route),
    .stat_o      (stat),
    .core_stat_o (core_stat),
    .irq_nxt_o   (irq_nxt)
  );

  irq_router_rd u_rd (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rd_en_i     (req_i && !we_i),
    .route_acc_i (route_acc),
    .word_acc_i  (word_acc),
    .addr_i      (addr_i),
    .route_i     (route),
    .en_i        (en),
    .stat_i      (stat),
    .core_stat_i (core_stat),
    .rvalid_o    (rvalid_o),
    .rdata_o     (rdata_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= '0;
    else         irq_q <= irq_nxt;
  end

  assign irq_o = irq_q;

  p_irq_cause_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(|stat) |=> (irq_o == '0));
  p_irq_src_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|irq_nxt) |=> (|irq_o));
endmodule

// File: tb/irq_router_tb_top.sv
module irq_router_tb_top;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] pins = '0;
  logic        req = 1'b0;
  logic        we = 1'b0;
  logic [1:0]  size = 2'd0;
  logic [6:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic        rvalid;
  logic [31:0] rdata;
  logic [15:0] irq;

  int checks = 0;
  int errors = 0;
  string cur_tag = "R9";

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_router dut_i (
    .clk_i(clk), .rst_ni(rst_n), .irq_i(pins), .req_i(req), .we_i(we),
    .size_i(size), .addr_i(addr), .wdata_i(wdata), .rvalid_o(rvalid),
    .rdata_o(rdata), .irq_o(irq)
  );

  // behavioural reference
  logic [7:0]  m_route [32];
  logic [31:0] m_en;
  logic [15:0] exp_irq;
  logic        exp_rvalid;
  logic [31:0] exp_rdata;

  function automatic logic [15:0] m_outputs();
    logic [15:0] r = '0;
    for (int c = 0; c < 4; c++) begin
      for (int l = 0; l < 4; l++) begin
        bit ca = 0, la = 0;
        for (int i = 0; i < 32; i++) begin
          if (pins[i] && m_en[i]) begin
            if (m_route[i][c]) ca = 1;
            if (m_route[i][4+l]) la = 1;
          end
        end
        r[c*4+l] = ca && la;
      end
    end
    return r;
  endfunction

  function automatic logic [31:0] m_read(logic [6:0] a, logic [1:0] s);
    logic [31:0] v = '0;
    if (s == 2'd0 && a < 7'd32) return {24'd0, m_route[a[4:0]]};
    if (s != 2'd2 || a[1:0] != 2'b00) return '0;
    if (a == 7'h20) return pins & m_en;
    if (a == 7'h24) return m_en;
    for (int c = 0; c < 4; c++) begin
      if (int'(a) == 'h40 + 8*c) begin
        for (int i = 0; i < 32; i++) v[i] = pins[i] && m_en[i] && m_route[i][c];
      end
    end
    return v;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 32; i++) m_route[i] = '0;
      m_en = '0;
      exp_irq = '0;
      exp_rvalid = 1'b0;
      exp_rdata = '0;
    end else begin
      exp_irq = m_outputs();
      exp_rvalid = req && !we;
      exp_rdata = (req && !we) ? m_read(addr, size) : '0;
      if (req && we) begin
        if (size == 2'd0 && addr < 7'd32) m_route[addr[4:0]] = wdata[7:0];
        else if (size == 2'd2 && addr == 7'h28) m_en = m_en | wdata;
        else if (size == 2'd2 && addr == 7'h2C) m_en = m_en & ~wdata;
      end
    end
  end

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // continuous comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      check(irq == exp_irq, "R7", 32'(irq), 32'(exp_irq));
      check(rvalid == exp_rvalid, "R9", 32'(rvalid), 32'(exp_rvalid));
      if (exp_rvalid) check(rdata == exp_rdata, cur_tag, rdata, exp_rdata);
    end
  end

  task automatic acc(bit w, logic [1:0] s, logic [6:0] a, logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = w; size = s; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic rd_expect(logic [1:0] s, logic [6:0] a, logic [31:0] e, string tag);
    cur_tag = tag;
    acc(1'b0, s, a, '0);
    check(rvalid && rdata == e, tag, rdata, e);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(irq == '0 && rvalid == 1'b0, "R1", 32'(irq), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(irq == '0, "R1", 32'(irq), 0);
    rd_expect(2'd2, 7'h24, 32'h0, "R1");
    rd_expect(2'd0, 7'h05, 32'h0, "R1");

    // routing bytes
    acc(1'b1, 2'd0, 7'h03, 32'hFFFF_FF21);
    rd_expect(2'd0, 7'h03, 32'h21, "R2");
    acc(1'b1, 2'd2, 7'h00, 32'hFFFF_FFFF);
    rd_expect(2'd0, 7'h00, 32'h0, "R10");
    rd_expect(2'd2, 7'h00, 32'h0, "R10");

    // enables
    acc(1'b1, 2'd2, 7'h28, 32'h0000_000F);
    rd_expect(2'd2, 7'h24, 32'hF, "R4");
    acc(1'b1, 2'd2, 7'h2C, 32'h0000_0005);
    rd_expect(2'd2, 7'h24, 32'hA, "R5");
    acc(1'b1, 2'd1, 7'h28, 32'hFFFF_FFFF);
    rd_expect(2'd2, 7'h24, 32'hA, "R10");

    // enabled status is live
    pins = 32'h0000_00FF;
    rd_expect(2'd2, 7'h20, 32'hA, "R3");
    pins = 32'h0000_0008;
    rd_expect(2'd2, 7'h20, 32'h8, "R3");
    pins = '0;
    acc(1'b1, 2'd2, 7'h28, 32'h0000_000F);

    // one-cycle lag: input 3 -> core0 line1 = bit 1
    @(negedge clk);
    pins = 32'h0000_0008;
    #1 check(irq == '0, "R8", 32'(irq), 0);
    @(negedge clk);
    check(irq == 16'h0002, "R8", 32'(irq), 32'h2);
    pins = '0;

    // core from one input, line from another
    acc(1'b1, 2'd0, 7'h03, 32'h0);
    acc(1'b1, 2'd0, 7'h00, 32'h01);
    acc(1'b1, 2'd0, 7'h01, 32'h20);
    pins = 32'h0000_0003;
    @(negedge clk);
    @(negedge clk);
    check(irq == 16'h0002, "R7", 32'(irq), 32'h2);

    // per-core status
    rd_expect(2'd2, 7'h40, 32'h1, "R6");
    rd_expect(2'd2, 7'h48, 32'h0, "R6");
    acc(1'b1, 2'd2, 7'h40, 32'hFFFF_FFFF);
    rd_expect(2'd2, 7'h40, 32'h1, "R11");

    // illegal shapes and unmapped
    rd_expect(2'd1, 7'h24, 32'h0, "R10");
    rd_expect(2'd2, 7'h26, 32'h0, "R10");
    rd_expect(2'd0, 7'h24, 32'h0, "R10");
    rd_expect(2'd2, 7'h30, 32'h0, "R11");
    rd_expect(2'd2, 7'h44, 32'h0, "R11");
    acc(1'b1, 2'd2, 7'h24, 32'h0);
    acc(1'b1, 2'd2, 7'h20, 32'h0);
    rd_expect(2'd2, 7'h24, 32'hF, "R11");

    // fan-out of one input to every output
    pins = '0;
    acc(1'b1, 2'd0, 7'h05, 32'hFF);
    acc(1'b1, 2'd2, 7'h28, 32'h0000_0020);
    pins = 32'h0000_0020;
    @(negedge clk);
    @(negedge clk);
    check(irq == 16'hFFFF, "R7", 32'(irq), 32'hFFFF);
    rd_expect(2'd2, 7'h58, 32'h20, "R6");

    // random traffic against the model
    for (int n = 0; n < 3000; n++) begin
      logic [6:0] a;
      logic [1:0] s;
      int k = int'($urandom_range(0, 7));
      pins = $urandom();
      s = 2'($urandom_range(0, 3));
      case (k)
        0, 1: a = 7'($urandom_range(0, 31));
        2: a = 7'h28;
        3: a = 7'h2C;
        4: a = 7'h20 + 7'($urandom_range(0, 1) * 4);
        5: a = 7'h40 + 7'($urandom_range(0, 3) * 8);
        default: a = 7'($urandom_range(0, 127));
      endcase
      if (k < 2) s = 2'd0;
      else if (k < 6 && s != 2'd1) s = 2'd2;
      cur_tag = "R2";
      acc($urandom_range(0, 1) == 1, s, a, $urandom());
    end

    repeat (3) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule